// File: doc/BRIEF.md
# Interleaved Sub-Pipelined AES-128 Round Core

This block runs AES-128 with one round of hardware. Registers cut the round into stages, so several independent 128-bit blocks circulate through that loop together, each one stage apart. Encryption uses three stage registers and keeps three blocks in flight. Decryption uses the equivalent inverse cipher and adds a fourth register, so it keeps four blocks in flight. A group is always three blocks in encryption or four in decryption. Blocks enter on a valid/ready stream. The core asks for round keys by index on `key_idx`, and the surrounding key store answers on `round_key` in the same cycle. Processed blocks leave on a second valid/ready stream, and the last block of the group is flagged.

The first accepted block starts a group and sets its direction from `mode`. Each block is whitened with round key 0 as it enters. The block then passes the S-box inversion, which is split over the first two stages. The third stage holds the affine map, the row rotation, the column mix and the key addition. In decryption the key addition moves to a fourth stage behind the inverse column mix. Round 10 bypasses the column mix. Every slot carries its own round count and group position, so blocks that arrive with gaps still finish correctly. Results wait in a four-entry buffer until the downstream side takes them.

Top module: `aes_ring_core`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `key_idx` is 0.
- R2: With `mode`=0 at the first block, each of the three blocks comes out as its AES-128 encryption. This covers whitening with key 0, nine full rounds, and a last round with no MixColumns. For encryption `round_key` must carry expanded key number `key_idx`.
- R3: With `mode`=1 at the first block, each of the four blocks comes out as its AES-128 decryption. For decryption `round_key` must carry the inverse-cipher key: index 0 takes expanded key 10, index 10 takes expanded key 0, and index k between 1 and 9 takes InvMixColumns of expanded key 10-k.
- R4: `key_idx` is 0 whenever a block is accepted. In a group every round index 1 to 10 is requested exactly once per block: three times in encryption and four times in decryption.
- R5: When three encryption blocks are accepted on consecutive edges, `out_valid` rises 32 clock edges after the edge that accepted the first block.
- R6: When four decryption blocks are accepted on consecutive edges, `out_valid` rises 43 clock edges after the edge that accepted the first block.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values. `in_ready` stays 0 until the whole group has been taken.
- R8: Results leave in the order the blocks were accepted, one per handshake. `out_last` is 1 only with the final block of the group.
- R9: Gaps between input blocks are allowed. `in_ready` drops while a block is returning to the loop input, and results are unaffected.
- R10: `mode` is sampled only with the first block of a group. Changing it later neither changes the direction nor the group size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 encrypt, 1 decrypt; sampled with the first block |
| in_valid | input | 1 | Input block is valid |
| in_ready | output | 1 | Core accepts a block this cycle |
| in_data | input | 128 | Plaintext or ciphertext block, byte 0 in bits 127:120 |
| key_idx | output | 4 | Index of the round key needed this cycle |
| round_key | input | 128 | Round key for `key_idx`, same cycle |
| out_valid | output | 1 | Output block is valid |
| out_ready | input | 1 | Downstream takes the block |
| out_data | output | 128 | Processed block |
| out_last | output | 1 | Final block of the group |

## Verification
Each check samples at the falling edge, so it reads the values settled by the preceding rising edge. The bench counts rising edges from the edge that accepted the first block. With back-to-back input, `out_valid` must first be seen exactly 32 edges later in encryption and 43 edges later in decryption. After that, one block is expected per accepting edge. Round-key requests are tallied at every falling edge over a whole group and compared with the group size. Ciphertexts are compared against published AES-128 answers, and unknown blocks are checked by decrypting them back.

// File: rtl/aes_ring_pkg.sv
package aes_ring_pkg;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, t;
    p = '0;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= t;
      t = xt(t);
    end
    return p;
  endfunction

  function automatic logic [7:0] gsq(input logic [7:0] a);
    return gmul(a, a);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] b);
    return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] b);
    return rl(b, 1) ^ rl(b, 3) ^ rl(b, 6) ^ 8'h05;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  function automatic logic [31:0] imix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
            gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
            gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
            gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
  endfunction

endpackage

// File: rtl/aes_ring_s1.sv
// Stage 1: optional inverse affine, then the first half of x^254.
// Produces x^15 and x^14 for every byte.
module aes_ring_s1 import aes_ring_pkg::*; #(
  parameter int NB = 16
) (
  input  logic              dec,
  input  logic [8*NB-1:0]   st,
  output logic [16*NB-1:0]  pw
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] x, x2, x3, x12, x14, x15;
    always_comb begin
      x   = dec ? aff_inv(st[8*i +: 8]) : st[8*i +: 8];
      x2  = gsq(x);
      x3  = gmul(x2, x);
      x12 = gsq(gsq(x3));
      x15 = gmul(x12, x3);
      x14 = gmul(x12, x2);
    end
    assign pw[16*i +: 16] = {x15, x14};
  end
endmodule

// File: rtl/aes_ring_s2.sv
// Stage 2: x^254 = (x^15)^16 * x^14, the field inverse (0 maps to 0).
module aes_ring_s2 import aes_ring_pkg::*; #(
  parameter int NB = 16
) (
  input  logic [16*NB-1:0] pw,
  output logic [8*NB-1:0]  inv
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] y;
    always_comb begin
      y = gsq(gsq(gsq(gsq(pw[16*i+8 +: 8]))));
    end
    assign inv[8*i +: 8] = gmul(y, pw[16*i +: 8]);
  end
endmodule

// File: rtl/aes_ring_s3.sv
// Stage 3. Encryption: affine, row rotation, column mix (skipped in the
// last round) and key addition. Decryption: inverse row rotation only.
module aes_ring_s3 import aes_ring_pkg::*; #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] inv,
  input  logic            last,
  input  logic [8*NB-1:0] rk,
  output logic [8*NB-1:0] enc_o,
  output logic [8*NB-1:0] dsr_o
);
  localparam int W  = 8 * NB;
  localparam int NC = NB / 4;
  logic [W-1:0] sr;

  for (genvar c = 0; c < NC; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int K  = r + 4 * c;
      localparam int SF = r + 4 * ((c + r) % NC);
      localparam int SI = r + 4 * ((c + NC - r) % NC);
      assign sr[W-1-8*K -: 8]    = aff_fwd(inv[W-1-8*SF -: 8]);
      assign dsr_o[W-1-8*K -: 8] = inv[W-1-8*SI -: 8];
    end
    logic [31:0] mc;
    always_comb mc = last ? sr[W-1-32*c -: 32] : mix_col(sr[W-1-32*c -: 32]);
    assign enc_o[W-1-32*c -: 32] = mc ^ rk[W-1-32*c -: 32];
  end
endmodule

// File: rtl/aes_ring_s4.sv
// Stage 4 (decryption only): inverse column mix unless last round, then key.
module aes_ring_s4 import aes_ring_pkg::*; #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] st,
  input  logic            last,
  input  logic [8*NB-1:0] rk,
  output logic [8*NB-1:0] out
);
  localparam int W  = 8 * NB;
  localparam int NC = NB / 4;
  for (genvar c = 0; c < NC; c++) begin : g_col
    logic [31:0] m;
    always_comb m = last ? st[W-1-32*c -: 32] : imix_col(st[W-1-32*c -: 32]);
    assign out[W-1-32*c -: 32] = m ^ rk[W-1-32*c -: 32];
  end
endmodule

// File: rtl/aes_ring_core.sv
module aes_ring_core #(
  parameter int NR = 10,
  parameter int NB = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [8*NB-1:0]              in_data,
  output logic [$clog2(NR+1)-1:0]      key_idx,
  input  logic [8*NB-1:0]              round_key,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [8*NB-1:0]              out_data,
  output logic                         out_last
);
  localparam int W  = 8 * NB;
  localparam int RW = $clog2(NR + 1);
  localparam int CW = 3;
  localparam logic [CW-1:0] ENC_SLOTS = CW'(3);
  localparam logic [CW-1:0] DEC_SLOTS = CW'(4);
  localparam logic [RW-1:0] LAST_RND  = RW'(NR);

  // loop registers with per-slot tags
  logic [W-1:0]   r0_d, r2_d, r3_d;
  logic [2*W-1:0] r1_d;
  logic           v0, v1, v2, v3;
  logic [RW-1:0]  rn0, rn1, rn2, rn3;
  logic [1:0]     ix0, ix1, ix2, ix3;

  // group control
  logic           dec_q;
  logic [CW-1:0]  ld_cnt, done_cnt;
  logic [1:0]     oidx;
  logic [W-1:0]   ob [4];

  logic           cur_dec, fb_v, fb_last, fb_cont, in_fire, out_fire, out_end;
  logic [CW-1:0]  grp_len, len_q;
  logic [RW-1:0]  fb_rn;
  logic [1:0]     fb_ix, last_oidx;
  logic [W-1:0]   fb_d, s2_inv, s3_enc, s3_dsr, s4_out;
  logic [2*W-1:0] s1_pw;

  aes_ring_s1 #(.NB(NB)) u_s1 (.dec(dec_q), .st(r0_d), .pw(s1_pw));
  aes_ring_s2 #(.NB(NB)) u_s2 (.pw(r1_d), .inv(s2_inv));
  aes_ring_s3 #(.NB(NB)) u_s3 (.inv(r2_d), .last(rn2 == LAST_RND), .rk(round_key),
                               .enc_o(s3_enc), .dsr_o(s3_dsr));
  aes_ring_s4 #(.NB(NB)) u_s4 (.st(r3_d), .last(rn3 == LAST_RND), .rk(round_key),
                               .out(s4_out));

  always_comb begin
    cur_dec   = (ld_cnt == '0) ? mode : dec_q;
    grp_len   = cur_dec ? DEC_SLOTS : ENC_SLOTS;
    len_q     = dec_q ? DEC_SLOTS : ENC_SLOTS;
    last_oidx = dec_q ? 2'd3 : 2'd2;
    fb_v      = dec_q ? v3  : v2;
    fb_rn     = dec_q ? rn3 : rn2;
    fb_ix     = dec_q ? ix3 : ix2;
    fb_d      = dec_q ? s4_out : s3_enc;
    fb_last   = fb_v && (fb_rn == LAST_RND);
    fb_cont   = fb_v && !fb_last;
    out_valid = (done_cnt == len_q);
    in_ready  = !out_valid && (ld_cnt < grp_len) && !fb_v;
    in_fire   = in_valid && in_ready;
    out_fire  = out_valid && out_ready;
    out_end   = (oidx == last_oidx);
    key_idx   = fb_v ? fb_rn : '0;
    out_data  = ob[oidx];
    out_last  = out_valid && out_end;
  end

  // loop input register: feedback has priority, load only when loop exit is empty
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0; rn0 <= '0; ix0 <= '0; r0_d <= '0;
    end else begin
      v0 <= fb_cont || in_fire;
      if (fb_cont) begin
        r0_d <= fb_d;
        rn0  <= fb_rn + RW'(1);
        ix0  <= fb_ix;
      end else if (in_fire) begin
        r0_d <= in_data ^ round_key;
        rn0  <= RW'(1);
        ix0  <= ld_cnt[1:0];
      end
    end
  end

  // inner stage registers; data only moves with a valid slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      rn1 <= '0; rn2 <= '0; rn3 <= '0;
      ix1 <= '0; ix2 <= '0; ix3 <= '0;
      r1_d <= '0; r2_d <= '0; r3_d <= '0;
    end else begin
      v1 <= v0; rn1 <= rn0; ix1 <= ix0;
      v2 <= v1; rn2 <= rn1; ix2 <= ix1;
      v3 <= dec_q && v2;
      if (v0) r1_d <= s1_pw;
      if (v1) r2_d <= s2_inv;
      if (dec_q && v2) begin
        r3_d <= s3_dsr;
        rn3  <= rn2;
        ix3  <= ix2;
      end
    end
  end

  // group sequencing and result capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q <= 1'b0; ld_cnt <= '0; done_cnt <= '0; oidx <= '0;
      for (int i = 0; i < 4; i++) ob[i] <= '0;
    end else begin
      if (in_fire && ld_cnt == '0) dec_q <= mode;
      if (fb_last) ob[fb_ix] <= fb_d;
      if (out_fire && out_end) begin
        ld_cnt <= '0; done_cnt <= '0; oidx <= '0;
      end else begin
        if (in_fire)  ld_cnt   <= ld_cnt + CW'(1);
        if (fb_last)  done_cnt <= done_cnt + CW'(1);
        if (out_fire) oidx     <= oidx + 2'd1;
      end
    end
  end

  // ---------------- assertions ----------------
  p_enc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_q |=> $stable(r3_d));
  p_enc_nofour_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_q |-> !v3);
  p_ring_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({v3, v2, v1, v0}) <= (dec_q ? 4 : 3));
  p_load_key0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> key_idx == '0);
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
  p_ring_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(v0 || v1 || v2 || v3));
  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: tb/sim_aes_ring_core.sv
`timescale 1ns/1ps
module sim_aes_ring_core;
  logic         clk = 1'b0;
  logic         rst_n, mode, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [127:0] in_data, round_key, out_data;
  logic [3:0]   key_idx;
  logic         use_dec;
  logic [127:0] ekey [0:10];
  logic [127:0] dkey [0:10];
  logic [127:0] tx [4];
  logic [127:0] got [4];
  int checks = 0, errors = 0, cyc = 0, t0 = 0, lat = 0;
  int kcnt [0:15];

  localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_A  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_A  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] KEY_B = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_B  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_B  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] X1    = 128'h0123456789abcdeffedcba9876543210;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aes_ring_core u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .key_idx(key_idx), .round_key(round_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  always_comb round_key = (key_idx > 4'd10) ? '0 : (use_dec ? dkey[key_idx] : ekey[key_idx]);

  initial for (int i = 0; i < 16; i++) kcnt[i] = 0;
  always @(negedge clk) if (rst_n && key_idx != 4'd0) kcnt[key_idx] <= kcnt[key_idx] + 1;

  // ---- independent reference arithmetic for key preparation ----
  function automatic logic [7:0] bx(input logic [7:0] a);
    return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
  endfunction
  function automatic logic [7:0] bm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = bx(t);
    end
    return p;
  endfunction
  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] y = 0, r;
    for (int c = 1; c < 256; c++) if (bm(x, 8'(c)) == 8'h01) y = 8'(c);
    r = 8'h63;
    for (int i = 0; i < 8; i++)
      r[i] = r[i] ^ y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8];
    return r;
  endfunction
  function automatic logic [127:0] imc(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      {a0, a1, a2, a3} = s[127-32*c -: 32];
      o[127-32*c -: 32] = {bm(a0,8'h0e)^bm(a1,8'h0b)^bm(a2,8'h0d)^bm(a3,8'h09),
                           bm(a0,8'h09)^bm(a1,8'h0e)^bm(a2,8'h0b)^bm(a3,8'h0d),
                           bm(a0,8'h0d)^bm(a1,8'h09)^bm(a2,8'h0e)^bm(a3,8'h0b),
                           bm(a0,8'h0b)^bm(a1,8'h0d)^bm(a2,8'h09)^bm(a3,8'h0e)};
    end
    return o;
  endfunction

  task automatic load_keys(input logic [127:0] k, input logic dec);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb(t[23:16]), sb(t[15:8]), sb(t[7:0]), sb(t[31:24])} ^ {rc, 24'h0};
        rc = bx(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ekey[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    dkey[0] = ekey[10];
    dkey[10] = ekey[0];
    for (int r = 1; r < 10; r++) dkey[r] = imc(ekey[10-r]);
    use_dec = dec;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // push n blocks from tx[]; gap idle cycles after each; optional mode flip after first
  task automatic send(input int n, input logic m, input int gap, input logic flip);
    mode = m;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = tx[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0) begin
        t0 = cyc;
        if (flip) mode = ~m;
      end
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic collect(input int n, input string req_last);
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      while (!out_valid) @(negedge clk);
      if (i == 0) lat = cyc - t0;
      got[i] = out_data;
      chk(req_last, 128'(out_last), 128'(i == n - 1));
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic key_tally(input int base [0:15], input int per);
    for (int k = 1; k <= 10; k++) chk("R4 key reuse count", 128'(kcnt[k] - base[k]), 128'(per));
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 128'(out_valid), 128'd0);
    chk("R1 in_ready", 128'(in_ready), 128'd1);
    chk("R1 key_idx", 128'(key_idx), 128'd0);
  endtask

  logic [127:0] c1;
  task automatic t_enc_kat;
    int base [0:15];
    base = kcnt;
    load_keys(KEY_B, 1'b0);
    tx[0] = PT_B; tx[1] = X1; tx[2] = PT_B;
    fork
      send(3, 1'b0, 0, 1'b0);
      collect(3, "R8 out_last enc");
    join
    chk("R5 enc latency", 128'(lat), 128'd32);
    chk("R2 enc block0", got[0], CT_B);
    chk("R2 enc block2", got[2], CT_B);
    c1 = got[1];
    key_tally(base, 3);
  endtask

  task automatic t_dec_kat;
    int base [0:15];
    base = kcnt;
    load_keys(KEY_B, 1'b1);
    tx[0] = CT_B; tx[1] = c1; tx[2] = CT_B; tx[3] = CT_B;
    fork
      send(4, 1'b1, 0, 1'b0);
      collect(4, "R8 out_last dec");
    join
    chk("R6 dec latency", 128'(lat), 128'd43);
    chk("R3 dec block0", got[0], PT_B);
    chk("R3 dec round trip block1", got[1], X1);
    chk("R3 dec block2", got[2], PT_B);
    chk("R3 dec block3", got[3], PT_B);
    key_tally(base, 4);
  endtask

  task automatic t_gap;
    load_keys(KEY_A, 1'b0);
    tx[0] = PT_A; tx[1] = PT_A; tx[2] = PT_A;
    send(3, 1'b0, 2, 1'b0);
    collect(3, "R8 out_last gap");
    for (int i = 0; i < 3; i++) chk("R9 gapped input", got[i], CT_A);
  endtask

  task automatic t_backpressure;
    logic [127:0] d0;
    load_keys(KEY_A, 1'b1);
    for (int i = 0; i < 4; i++) tx[i] = CT_A;
    send(4, 1'b1, 0, 1'b0);
    while (!out_valid) @(negedge clk);
    d0 = out_data;
    chk("R3 first plaintext", d0, PT_A);
    repeat (5) begin
      @(negedge clk);
      chk("R7 valid held", 128'(out_valid), 128'd1);
      chk("R7 data held", out_data, d0);
      chk("R7 input blocked", 128'(in_ready), 128'd0);
    end
    collect(4, "R8 out_last bp");
    for (int i = 0; i < 4; i++) chk("R7 drained data", got[i], PT_A);
  endtask

  task automatic t_mode;
    load_keys(KEY_B, 1'b0);
    for (int i = 0; i < 3; i++) tx[i] = PT_B;
    send(3, 1'b0, 0, 1'b1);
    collect(3, "R10 group size from first mode");
    for (int i = 0; i < 3; i++) chk("R10 direction kept", got[i], CT_B);
    chk("R10 no fourth output", 128'(out_valid), 128'd0);
    mode = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    load_keys(KEY_A, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enc_kat;
    t_dec_kat;
    t_gap;
    t_backpressure;
    t_mode;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule